// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block moves a processor's full register context between the register file and a byte-wide stack in memory. When interrupt entry is signalled it copies the program counter, both index registers, both accumulators and the condition code register into a nine-byte frame. The frame grows downward from the current stack pointer. On a return request it reads the same frame back in the opposite order and presents the restored values together with the adjusted stack pointer.

The memory side is a synchronous single-port interface with one access per clock. Read data arrives one cycle after its address. Instruction decode, vector fetch and priority between interrupt sources belong to the surrounding core. The core holds the register inputs steady for the cycle in which it raises a request, and it consumes the outputs when `done` pulses.

Top module: `ctx_stacker`

## Requirements
- R1: A push drives `mem_we` high for exactly 9 consecutive cycles, with one byte written per cycle. The first write occurs in the cycle after the edge that accepts the request.
- R2: During a push, write number k (k = 0..8) goes to address SP−k. The bytes are written in this order: PC[7:0], PC[15:8], IY[7:0], IY[15:8], IX[7:0], IX[15:8], A, B, CCR. SP is `sp_in` at acceptance.
- R3: `done` is high in the cycle right after the last push write, and `sp_out` equals SP−9 in that cycle.
- R4: A pull reads addresses SP+1 through SP+9 in rising order. These bytes restore CCR, B, A, IX[15:8], IX[7:0], IY[15:8], IY[7:0], PC[15:8] and PC[7:0] in that order. `done` is high two cycles after the last read address, with all outputs restored and `sp_out` = SP+9. No write occurs during a pull.
- R5: `pc_out`, `ix_out`, `iy_out`, `acc_a_out`, `acc_b_out` and `ccr_out` change only in the `done` cycle of a pull. A push leaves them unchanged.
- R6: A request that is raised from the accepting edge up to, but not including, the `done` cycle has no effect. A request present during the `done` cycle is accepted.
- R7: When `push_req` and `pull_req` are both high in an idle cycle, the push is performed.
- R8: All stack addresses and the final stack pointer wrap modulo 2^16.
- R9: Under reset, `done` and `mem_we` are low, and all register outputs and `sp_out` are zero.
- R10: `done` is a single-cycle pulse, and `mem_we` is never high while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Save context (interrupt accepted) |
| pull_req | input | 1 | Restore context (return from interrupt) |
| pc_in | input | 16 | Current program counter |
| ix_in | input | 16 | Current index register X |
| iy_in | input | 16 | Current index register Y |
| acc_a_in | input | 8 | Current accumulator A |
| acc_b_in | input | 8 | Current accumulator B |
| ccr_in | input | 8 | Current condition code register |
| sp_in | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| pc_out | output | 16 | Restored program counter |
| ix_out | output | 16 | Restored index register X |
| iy_out | output | 16 | Restored index register Y |
| acc_a_out | output | 8 | Restored accumulator A |
| acc_b_out | output | 8 | Restored accumulator B |
| ccr_out | output | 8 | Restored condition code register |
| sp_out | output | 16 | Stack pointer after the last sequence |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each fault shows at the ports within one frame.
- A step counter that is off by one shows as a write burst that is not nine cycles long, or as a `done` pulse that comes early or late.
- A wrong address step shows on `mem_addr` in the second write cycle, and later in a wrong `sp_out`.
- A swapped byte slot, in either the snapshot or the restore shadow, appears as a wrong `mem_wdata` during the push. It also appears as a corrupted restored register when a frame is round-tripped, or when a frame is preloaded into memory by the bench.
- A busy flag that clears too early shows as a second burst of writes after `done`.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PUSH  = 2'd1,
    ST_PULL  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;

  localparam int unsigned FRAME_BYTES = 9;
endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_stack_pkg::*;
#(
  parameter int unsigned FRAME = FRAME_BYTES,
  localparam int unsigned CW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pull_req,
  output seq_state_e    st,
  output logic [CW-1:0] cnt,
  output logic          start_push,
  output logic          start_pull,
  output logic          last,
  output logic          done
);
  always_comb begin
    start_push = (st == ST_IDLE) && push_req;
    start_pull = (st == ST_IDLE) && !push_req && pull_req;
    last       = (cnt == CW'(FRAME - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= ((st == ST_PUSH) && last) || (st == ST_DRAIN);
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (start_push)      st <= ST_PUSH;
          else if (start_pull) st <= ST_PULL;
        end
        ST_PUSH: begin
          if (last) st  <= ST_IDLE;
          else      cnt <= cnt + 1'b1;
        end
        ST_PULL: begin
          if (last) st  <= ST_DRAIN;
          else      cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
  import ctx_stack_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    st,
  input  logic          start_push,
  input  logic          start_pull,
  input  logic          last,
  input  logic [AW-1:0] sp_in,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] sp_out
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      sp_out   <= '0;
    end else begin
      if (start_push)
        mem_addr <= sp_in;
      else if (start_pull)
        mem_addr <= sp_in + ONE;
      else if ((st == ST_PUSH) && !last)
        mem_addr <= mem_addr - ONE;
      else if ((st == ST_PULL) && !last)
        mem_addr <= mem_addr + ONE;

      if ((st == ST_PUSH) && last)
        sp_out <= mem_addr - ONE;
      else if (st == ST_DRAIN)
        sp_out <= mem_addr;
    end
  end
endmodule

// File: rtl/ctx_push_path.sv
module ctx_push_path
  import ctx_stack_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned FRAME = FRAME_BYTES,
  localparam int unsigned CW   = $clog2(FRAME),
  localparam int unsigned WW   = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    st,
  input  logic          start_push,
  input  logic          last,
  input  logic [CW-1:0] cnt,
  input  logic [WW-1:0] pc_in,
  input  logic [WW-1:0] ix_in,
  input  logic [WW-1:0] iy_in,
  input  logic [DW-1:0] acc_a_in,
  input  logic [DW-1:0] acc_b_in,
  input  logic [DW-1:0] ccr_in,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);
  logic [FRAME-1:0][DW-1:0] frm;
  logic [FRAME-1:0][DW-1:0] snap;
  logic [CW-1:0]            nxt;

  // Write order: low program counter byte first, condition codes last.
  always_comb begin
    frm[0] = pc_in[DW-1:0];
    frm[1] = pc_in[WW-1:DW];
    frm[2] = iy_in[DW-1:0];
    frm[3] = iy_in[WW-1:DW];
    frm[4] = ix_in[DW-1:0];
    frm[5] = ix_in[WW-1:DW];
    frm[6] = acc_a_in;
    frm[7] = acc_b_in;
    frm[8] = ccr_in;
    nxt    = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap      <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      mem_we <= start_push || ((st == ST_PUSH) && !last);
      if (start_push) begin
        snap      <= frm;
        mem_wdata <= frm[0];
      end else if ((st == ST_PUSH) && !last) begin
        mem_wdata <= snap[nxt];
      end
    end
  end
endmodule

// File: rtl/ctx_pull_path.sv
module ctx_pull_path
  import ctx_stack_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned FRAME = FRAME_BYTES,
  localparam int unsigned CW   = $clog2(FRAME),
  localparam int unsigned WW   = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    st,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] mem_rdata,
  output logic [WW-1:0] pc_out,
  output logic [WW-1:0] ix_out,
  output logic [WW-1:0] iy_out,
  output logic [DW-1:0] acc_a_out,
  output logic [DW-1:0] acc_b_out,
  output logic [DW-1:0] ccr_out
);
  logic [FRAME-2:0][DW-1:0] shadow;
  logic                     rd_vld;
  logic [CW-1:0]            rd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      rd_idx <= '0;
      shadow <= '0;
    end else begin
      rd_vld <= (st == ST_PULL);
      rd_idx <= cnt;
      if (rd_vld && (rd_idx != CW'(FRAME - 1)))
        shadow[rd_idx[CW-2:0]] <= mem_rdata;
    end
  end

  // Read order is the reverse of the write order; the final byte
  // (low program counter) is taken straight from the memory port.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out    <= '0;
      ix_out    <= '0;
      iy_out    <= '0;
      acc_a_out <= '0;
      acc_b_out <= '0;
      ccr_out   <= '0;
    end else if (st == ST_DRAIN) begin
      ccr_out   <= shadow[0];
      acc_b_out <= shadow[1];
      acc_a_out <= shadow[2];
      ix_out    <= {shadow[3], shadow[4]};
      iy_out    <= {shadow[5], shadow[6]};
      pc_out    <= {shadow[7], mem_rdata};
    end
  end
endmodule

// File: rtl/ctx_stacker.sv
module ctx_stacker
  import ctx_stack_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned WW = 2 * DW,
  localparam int unsigned CW = $clog2(FRAME_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pull_req,
  input  logic [WW-1:0] pc_in,
  input  logic [WW-1:0] ix_in,
  input  logic [WW-1:0] iy_in,
  input  logic [DW-1:0] acc_a_in,
  input  logic [DW-1:0] acc_b_in,
  input  logic [DW-1:0] ccr_in,
  input  logic [AW-1:0] sp_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [WW-1:0] pc_out,
  output logic [WW-1:0] ix_out,
  output logic [WW-1:0] iy_out,
  output logic [DW-1:0] acc_a_out,
  output logic [DW-1:0] acc_b_out,
  output logic [DW-1:0] ccr_out,
  output logic [AW-1:0] sp_out,
  output logic          done
);
  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          start_push;
  logic          start_pull;
  logic          last;

  ctx_seq_ctrl #(.FRAME(FRAME_BYTES)) ctrl_i (
    .clk(clk), .rst(rst), .push_req(push_req), .pull_req(pull_req),
    .st(st), .cnt(cnt), .start_push(start_push), .start_pull(start_pull),
    .last(last), .done(done)
  );

  ctx_addr_gen #(.AW(AW)) addr_i (
    .clk(clk), .rst(rst), .st(st), .start_push(start_push),
    .start_pull(start_pull), .last(last), .sp_in(sp_in),
    .mem_addr(mem_addr), .sp_out(sp_out)
  );

  ctx_push_path #(.DW(DW), .FRAME(FRAME_BYTES)) push_i (
    .clk(clk), .rst(rst), .st(st), .start_push(start_push), .last(last),
    .cnt(cnt), .pc_in(pc_in), .ix_in(ix_in), .iy_in(iy_in),
    .acc_a_in(acc_a_in), .acc_b_in(acc_b_in), .ccr_in(ccr_in),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  ctx_pull_path #(.DW(DW), .FRAME(FRAME_BYTES)) pull_i (
    .clk(clk), .rst(rst), .st(st), .cnt(cnt), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .ix_out(ix_out), .iy_out(iy_out),
    .acc_a_out(acc_a_out), .acc_b_out(acc_b_out), .ccr_out(ccr_out)
  );
endmodule

// File: rtl/ctx_stack_chk.sv
module ctx_stack_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned FRAME = 9
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_we,
  input logic [2*DW-1:0] pc_out,
  input logic [2*DW-1:0] ix_out,
  input logic [DW-1:0]   ccr_out,
  input logic [AW-1:0]   sp_out,
  input logic            done
);
  logic [7:0] wr_run;

  always_ff @(posedge clk) begin
    if (rst)         wr_run <= '0;
    else if (mem_we) wr_run <= wr_run + 1'b1;
    else             wr_run <= '0;
  end

  p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(wr_run) < FRAME));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

  p_done_after_push_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> done);

  p_push_sp_r3: assert property (@(posedge clk) disable iff (rst)
    (done && $past(mem_we)) |-> (sp_out == $past(mem_addr) - AW'(1)));

  p_regs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pc_out) && $stable(ix_out) && $stable(ccr_out)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_write_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);
endmodule

bind ctx_stacker ctx_stack_chk #(.AW(AW), .DW(DW), .FRAME(9)) chk_i (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .pc_out(pc_out), .ix_out(ix_out), .ccr_out(ccr_out),
  .sp_out(sp_out), .done(done)
);

// File: tb/ctx_stacker_tb_top.sv
`timescale 1ns/1ps
module ctx_stacker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_req = 1'b0, pull_req = 1'b0;
  logic [15:0] pc_in = '0, ix_in = '0, iy_in = '0, sp_in = '0;
  logic [7:0]  acc_a_in = '0, acc_b_in = '0, ccr_in = '0;
  logic [15:0] mem_addr, pc_out, ix_out, iy_out, sp_out;
  logic [7:0]  mem_wdata, mem_rdata, acc_a_out, acc_b_out, ccr_out;
  logic        mem_we, done;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  ctx_stacker dut_i (
    .clk(clk), .rst(rst), .push_req(push_req), .pull_req(pull_req),
    .pc_in(pc_in), .ix_in(ix_in), .iy_in(iy_in), .acc_a_in(acc_a_in),
    .acc_b_in(acc_b_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .ix_out(ix_out), .iy_out(iy_out),
    .acc_a_out(acc_a_out), .acc_b_out(acc_b_out), .ccr_out(ccr_out),
    .sp_out(sp_out), .done(done)
  );

  // memory model: synchronous, one-cycle read latency
  logic [7:0] mem [logic [15:0]];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] = mem_wdata;
    mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
  end

  // write monitor
  logic [15:0] w_addr [0:31];
  logic [7:0]  w_data [0:31];
  int          wcnt = 0;
  always @(negedge clk) begin
    if (mem_we && wcnt < 32) begin
      w_addr[wcnt] = mem_addr;
      w_data[wcnt] = mem_wdata;
    end
    if (mem_we) wcnt = wcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k, input logic [15:0] pc,
      input logic [15:0] ix, input logic [15:0] iy,
      input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    case (k)
      0: return pc[7:0];
      1: return pc[15:8];
      2: return iy[7:0];
      3: return iy[15:8];
      4: return ix[7:0];
      5: return ix[15:8];
      6: return a;
      7: return b;
      default: return c;
    endcase
  endfunction

  // drive a request for one cycle, return negedges until done (0 = none)
  task automatic request(input bit do_push, input bit do_pull, output int lat);
    @(negedge clk);
    wcnt     = 0;
    push_req = do_push;
    pull_req = do_pull;
    @(negedge clk);
    push_req = 1'b0;
    pull_req = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (!done) lat = 0;
  endtask

  task automatic set_regs(input logic [15:0] pc, ix, iy, sp,
                          input logic [7:0] a, b, c);
    pc_in = pc; ix_in = ix; iy_in = iy; sp_in = sp;
    acc_a_in = a; acc_b_in = b; ccr_in = c;
  endtask

  // full save/restore round trip with checks
  task automatic round_trip(input logic [15:0] pc, ix, iy, sp,
                            input logic [7:0] a, b, c);
    int lat;
    logic [15:0] pc0, ix0;
    logic [7:0]  c0;
    bit ok;
    pc0 = pc_out; ix0 = ix_out; c0 = ccr_out;
    @(negedge clk);
    set_regs(pc, ix, iy, sp, a, b, c);
    request(1'b1, 1'b0, lat);
    chk(lat == 10, "R3", "push done latency", lat, 10);
    chk(wcnt == 9, "R1", "push write count", wcnt, 9);
    ok = 1'b1;
    for (int k = 0; k < 9; k++) begin
      if (w_addr[k] !== 16'(sp - 16'(k))) ok = 1'b0;
      if (w_data[k] !== fbyte(k, pc, ix, iy, a, b, c)) ok = 1'b0;
    end
    chk(ok, "R2", "push frame layout (R8 when wrapping)", {w_addr[8], w_data[8]},
        {16'(sp - 16'd8), c});
    chk(sp_out === 16'(sp - 16'd9), "R3", "sp after push", sp_out, 16'(sp - 16'd9));
    chk(pc_out === pc0 && ix_out === ix0 && ccr_out === c0, "R5",
        "outputs held by push", pc_out, pc0);
    // scramble the inputs so restore must come from memory
    @(negedge clk);
    set_regs(~pc, ~ix, ~iy, 16'(sp - 16'd9), ~a, ~b, ~c);
    request(1'b0, 1'b1, lat);
    chk(lat == 11, "R4", "pull done latency", lat, 11);
    chk(wcnt == 0, "R4", "no write in pull", wcnt, 0);
    chk({pc_out, ix_out, iy_out} === {pc, ix, iy}, "R4", "restored words",
        {pc_out, ix_out[15:0]}, {pc, ix});
    chk({acc_a_out, acc_b_out, ccr_out} === {a, b, c}, "R4", "restored bytes",
        {acc_a_out, acc_b_out, ccr_out}, {a, b, c});
    chk(sp_out === sp, "R4", "sp after pull (R8 wrap)", sp_out, sp);
  endtask

  initial begin
    int lat;
    logic [15:0] base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(done == 1'b0 && mem_we == 1'b0, "R9", "reset controls", {done, mem_we}, 0);
    chk({pc_out, ix_out, iy_out, sp_out} == '0 && {acc_a_out, acc_b_out, ccr_out} == '0,
        "R9", "reset outputs", pc_out, 0);
    rst = 1'b0;

    // directed round trip
    round_trip(16'hC123, 16'h4455, 16'h6677, 16'h01FF, 8'hA1, 8'hB2, 8'hC3);
    // R8 wrap through zero
    round_trip(16'h1357, 16'h2468, 16'h9ABC, 16'h0003, 8'h11, 8'h22, 8'h33);
    round_trip(16'hFFFF, 16'h0000, 16'h8001, 16'h0000, 8'hFF, 8'h00, 8'h80);

    // R4 pull order against a preloaded frame
    base = 16'h0200;
    for (int i = 1; i <= 9; i++) mem[16'(base + 16'(i))] = 8'(8'h40 + i);
    @(negedge clk);
    sp_in = base;
    request(1'b0, 1'b1, lat);
    chk(ccr_out == 8'h41 && acc_b_out == 8'h42 && acc_a_out == 8'h43, "R4",
        "preloaded low slots", {ccr_out, acc_b_out, acc_a_out}, 24'h414243);
    chk(ix_out == 16'h4445 && iy_out == 16'h4647 && pc_out == 16'h4849, "R4",
        "preloaded words", {pc_out, ix_out}, 32'h48494445);

    // R7 simultaneous requests: push wins
    @(negedge clk);
    set_regs(16'hABCD, 16'h1111, 16'h2222, 16'h0300, 8'h01, 8'h02, 8'h03);
    request(1'b1, 1'b1, lat);
    chk(lat == 10 && wcnt == 9, "R7", "push chosen on tie", {lat[15:0], 16'(wcnt)},
        {16'd10, 16'd9});

    // R6 requests during a busy push are ignored
    @(negedge clk);
    set_regs(16'h5A5A, 16'h6B6B, 16'h7C7C, 16'h0400, 8'h0D, 8'h0E, 8'h0F);
    wcnt = 0;
    push_req = 1'b1;
    @(negedge clk);
    push_req = 1'b0;
    repeat (2) @(negedge clk);
    set_regs(16'h0000, 16'h0000, 16'h0000, 16'h0800, 8'h00, 8'h00, 8'h00);
    push_req = 1'b1;
    pull_req = 1'b1;
    repeat (5) @(negedge clk);
    push_req = 1'b0;
    pull_req = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk(done, "R6", "push completes", done, 1);
    chk(w_data[8] == 8'h0F && w_addr[8] == 16'h03F8 && sp_out == 16'h03F7, "R6",
        "frame not disturbed", {w_addr[8], w_data[8]}, {16'h03F8, 8'h0F});
    @(negedge clk);
    chk(!done, "R10", "done single pulse", done, 0);
    repeat (4) @(negedge clk);
    chk(wcnt == 9 && !done, "R6", "no extra sequence", wcnt, 9);

    // R6 request in the done cycle is accepted
    @(negedge clk);
    set_regs(16'h1234, 16'h5678, 16'h9ABC, 16'h0500, 8'h21, 8'h43, 8'h65);
    request(1'b1, 1'b0, lat);
    set_regs(16'h1234, 16'h5678, 16'h9ABC, 16'h04F7, 8'h21, 8'h43, 8'h65);
    pull_req = 1'b1;
    @(negedge clk);
    pull_req = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == 11 && pc_out == 16'h1234, "R6", "back-to-back pull accepted",
        {lat[15:0], pc_out}, {16'd11, 16'h1234});

    // constrained random round trips
    for (int t = 0; t < 20; t++) begin
      round_trip(16'($urandom), 16'($urandom), 16'($urandom),
                 (t % 4 == 0) ? 16'($urandom_range(0, 8)) : 16'($urandom),
                 8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule